// File: doc/BRIEF.md
# Mark and Replay FIFO

A single-clock first-in first-out buffer that can pin its current read position as a mark and later rewind reads to that position, so a block of data can be played out again. Writes, reads, a mark request and a rewind request share one clock. The buffer reports when it is empty or when a word is ready, when it is full, half full, almost empty and almost full.

While a mark is held, the slots from the mark onward count as occupied for the full and almost-full flags. Writes therefore stop before they could overwrite data that a rewind may still need. A mark is taken only when enough data is queued. A new mark or a reset releases the old one. A parameter selects the output view. In standard mode, a read loads the word into an output register one cycle later. In first-word-fall-through mode, the head word is always on the output while the ready flag is high.

Top module: `mark_replay_fifo`

## Requirements
- R1: After reset the buffer holds no data and no mark. Flags are: status 1 in standard mode (0 in fall-through mode), full 0, half 0, almost-empty 1, almost-full 0. In standard mode rd_data is 0.
- R2: In standard mode, an accepted read copies the oldest word to rd_data at the clock edge that accepts it. Words leave in write order.
- R3: In fall-through mode, status is 1 exactly when data is queued, and rd_data then shows the oldest word.
- R4: full is 1 when the held span equals DEPTH. The held span is write pointer minus mark while a mark is active, otherwise write pointer minus read pointer. A write while full is dropped.
- R5: A mark request is accepted when the fill level (write minus read) is at least MIN_MARK. An accepted mark stores the current read position.
- R6: A mark request with fill below MIN_MARK is ignored, and any earlier mark stays in force.
- R7: While a mark is active, writes stop once the write pointer is DEPTH slots past the mark, even if reads have freed space.
- R8: A rewind with an active mark loads the read pointer with the mark. The following reads replay the data from the marked word. A rewind with no mark is ignored.
- R9: A rewind takes priority over a read or a mark request in the same cycle. That read is not performed, and that mark request is ignored.
- R10: half is fill ≥ DEPTH/2, almost-empty is fill ≤ AE_OFS, and almost-full is held span ≥ DEPTH−AF_OFS. After a rewind, all three are computed from the rewound read pointer.
- R11: An accepted new mark moves the mark to the current read position and releases the hold of the old mark.
- R12: A read while the buffer is empty is ignored. In standard mode, status is 1 exactly when fill is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output word (registered in standard mode, head word in fall-through mode) |
| mark_req | input | 1 | Request to mark the current read position |
| rewind_req | input | 1 | Request to rewind reads to the mark |
| status_o | output | 1 | Empty (standard) or word-ready (fall-through) |
| full_o | output | 1 | Held span equals DEPTH |
| half_o | output | 1 | Fill at least half of DEPTH |
| aempty_o | output | 1 | Fill at or below AE_OFS |
| afull_o | output | 1 | Held span at or above DEPTH−AF_OFS |

## Verification
Assertions check the following on every cycle:
- The write pointer does not move while the held span is full under a mark.
- A rewind loads the mark into the read pointer.
- A rejected mark leaves the mark register and its valid bit untouched.
- An accepted mark captures the read position.
- The read pointer does not move while the buffer is empty.

Other behaviours can only be shown by the bench's scenarios, run against an independent model:
- replay of the exact words after a rewind;
- a full flag that stays raised while reads have drained data;
- the release of that hold by a fresh mark;
- the priority of a rewind over a read issued in the same cycle.

// File: rtl/mrf_pkg.sv
`timescale 1ns/1ps
package mrf_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } out_mode_e;

  // distance from trail to lead on a ring of 2**pw positions
  function automatic logic [31:0] ring_gap(input logic [31:0] lead,
                                           input logic [31:0] trail,
                                           input int unsigned pw);
    logic [31:0] msk;
    msk = (32'd1 << pw) - 32'd1;
    return (lead - trail) & msk;
  endfunction

endpackage

// File: rtl/mrf_store.sv
`timescale 1ns/1ps
module mrf_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rword
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rword = mem[raddr];

endmodule

// File: rtl/mrf_ptr_ctrl.sv
`timescale 1ns/1ps
module mrf_ptr_ctrl
  import mrf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int MIN_MARK = 4,
  localparam int PW      = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          mark_req,
  input  logic          rewind_req,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] fill,
  output logic [PW-1:0] used,
  output logic          wr_fire,
  output logic          rd_fire
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] MIN_P   = PW'(MIN_MARK);

  logic [PW-1:0] wr_q, rd_q, mk_q;
  logic          mk_on_q;

  // named events for the assertions
  logic rewind_fire, mark_fire, mark_reject, span_full;

  assign fill = PW'(ring_gap(32'(wr_q), 32'(rd_q), PW));
  assign used = mk_on_q ? PW'(ring_gap(32'(wr_q), 32'(mk_q), PW)) : fill;

  assign span_full   = (used == DEPTH_P);
  assign rewind_fire = rewind_req && mk_on_q;
  assign rd_fire     = rd_req && (fill != '0) && !rewind_fire;
  assign mark_fire   = mark_req && !rewind_fire && (fill >= MIN_P);
  assign mark_reject = mark_req && !rewind_fire && !mark_fire;
  assign wr_fire     = wr_req && !span_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      mk_q    <= '0;
      mk_on_q <= 1'b0;
    end else begin
      if (wr_fire) wr_q <= wr_q + 1'b1;
      if (rewind_fire)  rd_q <= mk_q;
      else if (rd_fire) rd_q <= rd_q + 1'b1;
      if (mark_fire) begin
        mk_q    <= rd_q;
        mk_on_q <= 1'b1;
      end
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;

  assert_hold_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_on_q && span_full) |=> $stable(wr_q));

  assert_rewind_loads_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_fire |=> (rd_q == $past(mk_q)));

  assert_reject_keeps_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mark_reject |=> ($stable(mk_q) && $stable(mk_on_q)));

  assert_mark_takes_read_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mark_fire |=> (mk_on_q && (mk_q == $past(rd_q))));

  assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill == '0) && !rewind_fire) |=> $stable(rd_q));

endmodule

// File: rtl/mrf_flags.sv
`timescale 1ns/1ps
module mrf_flags
  import mrf_pkg::*;
#(
  parameter int        DEPTH  = 16,
  parameter int        AE_OFS = 2,
  parameter int        AF_OFS = 2,
  parameter out_mode_e MODE   = MODE_STD,
  localparam int       PW     = $clog2(DEPTH) + 1
) (
  input  logic [PW-1:0] fill,
  input  logic [PW-1:0] used,
  output logic          status,
  output logic          full,
  output logic          half,
  output logic          aempty,
  output logic          afull
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
  localparam logic [PW-1:0] AE_P    = PW'(AE_OFS);
  localparam logic [PW-1:0] AF_P    = PW'(DEPTH - AF_OFS);

  assign status = (MODE == MODE_FWFT) ? (fill != '0) : (fill == '0);
  assign full   = (used == DEPTH_P);
  assign half   = (fill >= HALF_P);
  assign aempty = (fill <= AE_P);
  assign afull  = (used >= AF_P);

endmodule

// File: rtl/mark_replay_fifo.sv
`timescale 1ns/1ps
module mark_replay_fifo
  import mrf_pkg::*;
#(
  parameter int        DATA_W   = 16,
  parameter int        DEPTH    = 16,
  parameter int        MIN_MARK = 4,
  parameter int        AE_OFS   = 2,
  parameter int        AF_OFS   = 2,
  parameter out_mode_e MODE     = MODE_STD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              mark_req,
  input  logic              rewind_req,
  output logic              status_o,
  output logic              full_o,
  output logic              half_o,
  output logic              aempty_o,
  output logic              afull_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]     wr_ptr, rd_ptr, fill, used;
  logic              wr_fire, rd_fire;
  logic [DATA_W-1:0] head_word;

  mrf_ptr_ctrl #(.DEPTH(DEPTH), .MIN_MARK(MIN_MARK)) ptr_i (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_en), .rd_req(rd_en),
    .mark_req(mark_req), .rewind_req(rewind_req),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .fill(fill), .used(used),
    .wr_fire(wr_fire), .rd_fire(rd_fire)
  );

  mrf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .we(wr_fire),
    .waddr(wr_ptr[AW-1:0]), .wdata(wr_data),
    .raddr(rd_ptr[AW-1:0]), .rword(head_word)
  );

  mrf_flags #(.DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS), .MODE(MODE)) flags_i (
    .fill(fill), .used(used),
    .status(status_o), .full(full_o), .half(half_o),
    .aempty(aempty_o), .afull(afull_o)
  );

  generate
    if (MODE == MODE_FWFT) begin : g_fwft
      assign rd_data = head_word;
    end else begin : g_std
      logic [DATA_W-1:0] dout_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= '0;
        else if (rd_fire) dout_q <= head_word;
      end
      assign rd_data = dout_q;
    end
  endgenerate

  assert_full_drops_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> $stable(wr_ptr));

endmodule

// File: tb/mark_replay_fifo_tb_top.sv
`timescale 1ns/1ps
module mark_replay_fifo_tb_top;
  import mrf_pkg::*;

  localparam int DW = 16, D = 16, MINM = 4, AE = 2, AF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, mark_req = 0, rewind_req = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] sd, fd;
  logic s_st, s_full, s_half, s_ae, s_af;
  logic f_st, f_full, f_half, f_ae, f_af;

  always #2.5 clk = ~clk;

  mark_replay_fifo #(.DATA_W(DW), .DEPTH(D), .MIN_MARK(MINM), .AE_OFS(AE), .AF_OFS(AF),
                     .MODE(MODE_STD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(sd), .mark_req(mark_req), .rewind_req(rewind_req),
    .status_o(s_st), .full_o(s_full), .half_o(s_half), .aempty_o(s_ae), .afull_o(s_af));

  mark_replay_fifo #(.DATA_W(DW), .DEPTH(D), .MIN_MARK(MINM), .AE_OFS(AE), .AF_OFS(AF),
                     .MODE(MODE_FWFT)) dut_fw_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(fd), .mark_req(mark_req), .rewind_req(rewind_req),
    .status_o(f_st), .full_o(f_full), .half_o(f_half), .aempty_o(f_ae), .afull_o(f_af));

  int tests = 0, fails = 0;
  bit finished = 0;

  // reference model on unbounded counters
  int unsigned m_wr = 0, m_rd = 0, m_mk = 0;
  bit m_on = 0;
  int unsigned m_mem [D];
  int unsigned m_out = 0;

  function automatic int unsigned fill_of();
    return m_wr - m_rd;
  endfunction
  function automatic int unsigned span_of();
    return m_on ? (m_wr - m_mk) : (m_wr - m_rd);
  endfunction

  task automatic chk(string tag, int unsigned got, int unsigned exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic model_edge(bit we, int unsigned d, bit re, bit mk, bit rw);
    bit do_rw, do_rd, do_mk, do_wr;
    int unsigned rd_old;
    do_rw  = rw && m_on;
    do_rd  = re && (fill_of() != 0) && !do_rw;
    do_mk  = mk && !do_rw && (fill_of() >= MINM);
    do_wr  = we && (span_of() != D);
    rd_old = m_rd;
    if (do_rd) begin m_out = m_mem[m_rd % D]; m_rd++; end
    if (do_rw) m_rd = m_mk;
    if (do_mk) begin m_mk = rd_old; m_on = 1; end
    if (do_wr) begin m_mem[m_wr % D] = d; m_wr++; end
  endtask

  task automatic compare_all();
    int unsigned f, s;
    f = fill_of(); s = span_of();
    chk("R12 standard status", s_st, (f == 0));
    chk("R3 fall-through ready", f_st, (f != 0));
    chk("R4 full flag", s_full, (s == D));
    chk("R4 full flag fwft", f_full, (s == D));
    chk("R10 half flag", s_half, (f >= D/2));
    chk("R10 almost-empty flag", s_ae, (f <= AE));
    chk("R10 almost-full flag", s_af, (s >= D-AF));
    chk("R2 standard output word", sd, m_out);
    if (f != 0) chk("R3 fall-through head word", fd, m_mem[m_rd % D]);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(bit we, int unsigned d, bit re, bit mk, bit rw);
    wr_en = we; wr_data = DW'(d); rd_en = re; mark_req = mk; rewind_req = rw;
    @(posedge clk);
    model_edge(we, d, re, mk, rw);
    @(negedge clk);
    wr_en = 0; rd_en = 0; mark_req = 0; rewind_req = 0;
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status after reset", s_st, 1);
    chk("R1 ready after reset fwft", f_st, 0);
    chk("R1 full after reset", s_full, 0);
    chk("R1 half after reset", s_half, 0);
    chk("R1 almost-empty after reset", s_ae, 1);
    chk("R1 almost-full after reset", s_af, 0);
    chk("R1 output after reset", sd, 0);

    // R12 read on empty ignored
    cyc(0, 0, 1, 0, 0);
    chk("R12 empty read leaves output", sd, 0);
    // R8 rewind without mark ignored
    cyc(0, 0, 0, 0, 1);
    chk("R8 rewind without mark keeps empty", s_st, 1);

    // fill past capacity: R4
    for (int i = 0; i < D + 2; i++) cyc(1, 32'h100 + i, 0, 0, 0);
    chk("R4 full after DEPTH writes", s_full, 1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0);
    chk("R2 third word out", sd, 32'h102);

    // R5 mark at read position 3
    cyc(0, 0, 0, 1, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0);
    chk("R2 eighth word out", sd, 32'h107);
    // R7 writes held back by the mark
    for (int i = 0; i < 4; i++) cyc(1, 32'h200 + i, 0, 0, 0);
    chk("R7 full while reads freed space", s_full, 1);
    chk("R7 fill below depth", s_st, 0);
    chk("R7 half still set", s_half, 1);

    // R9 rewind beats read in the same cycle
    cyc(0, 0, 1, 0, 1);
    chk("R9 read suppressed by rewind", sd, 32'h107);
    chk("R5 R8 marked word on fall-through output", fd, 32'h103);
    cyc(0, 0, 1, 0, 0);
    chk("R8 replay first word", sd, 32'h103);

    // drain to fill 3, then a rejected mark: R6
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 0, 0);
    chk("R10 almost-empty at fill 3", s_ae, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R6 old mark survives rejected request", fd, 32'h103);
    chk("R10 half recomputed after rewind", s_half, 1);

    // R9 mark and rewind together: mark ignored
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 1);
    chk("R9 mark ignored under rewind", fd, 32'h103);

    // R11 new mark releases the hold
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R11 full released by new mark", s_full, 0);
    cyc(1, 32'h300, 0, 0, 0);
    chk("R11 write accepted after release", s_af, 1);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      bit we, re, mk, rw;
      we = ($urandom_range(0, 99) < 60);
      re = ($urandom_range(0, 99) < 50);
      mk = ($urandom_range(0, 99) < 6);
      rw = ($urandom_range(0, 99) < 3);
      cyc(we, $urandom_range(0, 65535), re, mk, rw);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule